// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block derives a slower clock from its parent clock. The high time and the low time of the divided clock are programmed separately, each as a count of parent cycles. A control word holds a divide-enable bit and the two phase counts. While the enable bit is clear, the parent clock goes straight to the output with no division. A separate gate register can hold the output low without stopping the internal phase sequence.

Software writes and reads the two registers through a plain synchronous port. The port has a write strobe, a read strobe and a one-bit register select. A new phase setting never cuts into a period that is already running. It is taken up when the current low phase ends. The gate is switched only while the divided clock is low, so the output never carries a runt pulse. The gate can be left out at build time, and the output is then always enabled.

Top module: `hlclkdiv`

## Requirements
- R1: While the active divide-enable is 0, the output equals the parent clock ANDed with the gate state. The divider is then in bypass, a divide ratio of 1.
- R2: While dividing, each high phase lasts exactly (high count + 1) parent cycles.
- R3: While dividing, each low phase lasts exactly (low count + 1) parent cycles. With both counts at 0 the ratio is 2, the smallest possible.
- R4: The control word has the enable at bit 0, the high count at bits [HI_W:1] and the low count at bits [HI_W+LO_W:HI_W+1]. With the defaults these are bits 0, [8:1] and [16:9].
- R5: The gate register bit 0 enables the output when 1. When it is 0 the output stays low, in both bypass and divide mode.
- R6: When HAS_GATE is 0, gate writes are ignored, the gate register reads back 1 and the output is never held low by the gate.
- R7: After reset the control word reads 0, the gate reads 1, and the output is the bypassed parent clock.
- R8: A control write that arrives while dividing takes effect only at the end of the low phase in progress. The high phase in progress and the following low phase keep their old lengths.
- R9: The gate state changes only while the divided output is low. A high phase in progress is never shortened, and a high phase is never started part way through.
- R10: A read strobe returns the selected register on rdata one cycle later: select 0 gives the control word, select 1 gives the gate. Bits beyond the defined fields read 0, even if 1s were written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 gate |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| clk_div_o | output | 1 | Divided (or bypassed) and gated clock |

## Verification
Two functions can meet in the same cycle. One is a software update, either a new phase setting or a gate change. The other is the divider's own phase boundary. The bench provokes the first case by writing new counts a few cycles into a high phase, then checks the lengths of the following four phases: two at the old setting, then two at the new one. It provokes the second case by closing the gate in the middle of a high phase and reopening it at an arbitrary point. It judges both by the length of the last full high pulse and by the number of falling edges seen, so a truncated or partial pulse would show up as a wrong length or an extra fall.

// File: rtl/hlclkdiv_pkg.sv
package hlclkdiv_pkg;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_GATE = 1'b1
    } reg_sel_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int GATE_ON_BIT = 0;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hlclkdiv_regs.sv
module hlclkdiv_regs
    import hlclkdiv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int HI_W     = 8,
    parameter int LO_W     = 8,
    parameter int HAS_GATE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              cfg_en,
    output logic [HI_W-1:0]   cfg_hi,
    output logic [LO_W-1:0]   cfg_lo,
    output logic              gate_req
);

    localparam int HI_LSB = CTRL_EN_BIT + 1;
    localparam int HI_MSB = HI_LSB + HI_W - 1;
    localparam int LO_LSB = HI_MSB + 1;
    localparam int LO_MSB = LO_LSB + LO_W - 1;

    typedef struct packed {
        logic              en;
        logic [HI_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
        logic              gate;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t       r_d, r_q;
    reg_sel_e    sel;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] gate_view;

    // Upper write-data bits carry no field; fold them into a sink.
    generate
        if (DATA_W > LO_MSB + 1) begin : g_spare
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[DATA_W-1:LO_MSB+1];
        end
    endgenerate

    always_comb begin
        sel = reg_sel_e'(reg_sel);

        ctrl_view                  = '0;
        ctrl_view[CTRL_EN_BIT]     = r_q.en;
        ctrl_view[HI_MSB:HI_LSB]   = r_q.hi;
        ctrl_view[LO_MSB:LO_LSB]   = r_q.lo;

        gate_view                  = '0;
        gate_view[GATE_ON_BIT]     = r_q.gate;

        r_d = r_q;

        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    r_d.en = wdata[CTRL_EN_BIT];
                    r_d.hi = wdata[HI_MSB:HI_LSB];
                    r_d.lo = wdata[LO_MSB:LO_LSB];
                end
                SEL_GATE: begin
                    // A channel built without a gate keeps it open.
                    r_d.gate = (HAS_GATE != 0) ? wdata[GATE_ON_BIT] : 1'b1;
                end
            endcase
        end

        if (rd_en) begin
            r_d.rdata = (sel == SEL_CTRL) ? ctrl_view : gate_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, hi: '0, lo: '0, gate: 1'b1, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata    = r_q.rdata;
    assign cfg_en   = r_q.en;
    assign cfg_hi   = r_q.hi;
    assign cfg_lo   = r_q.lo;
    assign gate_req = r_q.gate;

endmodule

// File: rtl/hlclkdiv_phase.sv
module hlclkdiv_phase
    import hlclkdiv_pkg::*;
#(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic [HI_W-1:0] cfg_hi,
    input  logic [LO_W-1:0] cfg_lo,
    output logic            act_en,
    output logic            phase,
    output logic            phase_nxt,
    output logic [HI_W-1:0] act_hi,
    output logic [LO_W-1:0] act_lo
);

    localparam int CNT_W = wider(HI_W, LO_W);

    typedef struct packed {
        logic             en;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } ph_t;

    ph_t  s_d, s_q;
    logic cnt_done;
    logic take_cfg;

    always_comb begin
        cnt_done = (s_q.cnt == '0);
        // New settings are sampled in bypass or at the close of a low phase.
        take_cfg = !s_q.en || (cnt_done && !s_q.phase);

        s_d = s_q;

        if (take_cfg) begin
            if (cfg_en) begin
                s_d.en    = 1'b1;
                s_d.hi    = cfg_hi;
                s_d.lo    = cfg_lo;
                s_d.phase = 1'b1;
                s_d.cnt   = CNT_W'(cfg_hi);
            end else begin
                s_d.en    = 1'b0;
                s_d.phase = 1'b0;
                s_d.cnt   = '0;
            end
        end else if (!cnt_done) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else begin
            // End of the high phase: begin the low phase.
            s_d.phase = 1'b0;
            s_d.cnt   = CNT_W'(s_q.lo);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_en    = s_q.en;
    assign phase     = s_q.phase;
    assign phase_nxt = s_d.phase;
    assign act_hi    = s_q.hi;
    assign act_lo    = s_q.lo;

endmodule

// File: rtl/hlclkdiv_gate.sv
module hlclkdiv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic phase_nxt,
    output logic gate_act,
    output logic byp_gate
);

    typedef struct packed {
        logic on;
    } gt_t;

    gt_t  g_d, g_q;
    logic byp_q;

    always_comb begin
        g_d = g_q;
        // Follow the request only when the divided phase will be low.
        if (!phase_nxt) begin
            g_d.on = gate_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{on: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    // Bypass path: retime on the falling edge so the AND with the parent
    // clock only changes while that clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b1;
        end else begin
            byp_q <= g_q.on;
        end
    end

    assign gate_act = g_q.on;
    assign byp_gate = byp_q;

endmodule

// File: rtl/hlclkdiv.sv
module hlclkdiv
    import hlclkdiv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int HI_W     = 8,
    parameter int LO_W     = 8,
    parameter int HAS_GATE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              clk_div_o
);

    logic            cfg_en;
    logic [HI_W-1:0] cfg_hi;
    logic [LO_W-1:0] cfg_lo;
    logic            gate_req;
    logic            act_en;
    logic            phase;
    logic            phase_nxt;
    logic [HI_W-1:0] act_hi;
    logic [LO_W-1:0] act_lo;
    logic            gate_act;
    logic            byp_gate;

    hlclkdiv_regs #(
        .DATA_W  (DATA_W),
        .HI_W    (HI_W),
        .LO_W    (LO_W),
        .HAS_GATE(HAS_GATE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .cfg_en  (cfg_en),
        .cfg_hi  (cfg_hi),
        .cfg_lo  (cfg_lo),
        .gate_req(gate_req)
    );

    hlclkdiv_phase #(
        .HI_W(HI_W),
        .LO_W(LO_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_hi   (cfg_hi),
        .cfg_lo   (cfg_lo),
        .act_en   (act_en),
        .phase    (phase),
        .phase_nxt(phase_nxt),
        .act_hi   (act_hi),
        .act_lo   (act_lo)
    );

    hlclkdiv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_req (gate_req),
        .phase_nxt(phase_nxt),
        .gate_act (gate_act),
        .byp_gate (byp_gate)
    );

    assign clk_div_o = act_en ? (phase & gate_act) : (clk & byp_gate);

endmodule

// File: rtl/hlclkdiv_chk.sv
module hlclkdiv_chk #(
    parameter int HI_W     = 8,
    parameter int LO_W     = 8,
    parameter int HAS_GATE = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            act_en,
    input logic            phase,
    input logic [HI_W-1:0] act_hi,
    input logic [LO_W-1:0] act_lo,
    input logic            gate_act
);

    logic [HI_W:0] hrun_q;
    logic [LO_W:0] lrun_q;
    logic [HI_W:0] hi_len;
    logic [LO_W:0] lo_len;

    assign hi_len = {1'b0, act_hi} + 1'b1;
    assign lo_len = {1'b0, act_lo} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hrun_q <= '0;
            lrun_q <= '0;
        end else begin
            hrun_q <= phase ? hrun_q + 1'b1 : '0;
            if (phase) begin
                lrun_q <= '0;
            end else if (lrun_q != '1) begin
                lrun_q <= lrun_q + 1'b1;
            end
        end
    end

    assert_bypass_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> !phase);

    assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && $past(phase)) |-> (hrun_q == hi_len));

    assert_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !$past(phase) && $past(act_en)) |-> (lrun_q == $past(lo_len)));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hi != $past(act_hi)) |-> (phase && !$past(phase)));

    assert_gate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_act != $past(gate_act)) |-> !phase);

    generate
        if (HAS_GATE == 0) begin : g_nogate
            assert_gate_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
                gate_act);
        end
    endgenerate

endmodule

bind hlclkdiv hlclkdiv_chk #(
    .HI_W    (HI_W),
    .LO_W    (LO_W),
    .HAS_GATE(HAS_GATE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_en  (act_en),
    .phase   (phase),
    .act_hi  (act_hi),
    .act_lo  (act_lo),
    .gate_act(gate_act)
);

// File: tb/hlclkdiv_bench.sv
module hlclkdiv_bench;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_m, rdata_n;
    logic          out_m, out_n;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    hlclkdiv #(.DATA_W(DW), .HAS_GATE(1)) u_hlclkdiv (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata_m), .clk_div_o(out_m)
    );

    hlclkdiv #(.DATA_W(DW), .HAS_GATE(0)) u_hlclkdiv_ng (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata_n), .clk_div_o(out_n)
    );

    task automatic check(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R4 layout: enable bit 0, high count [8:1], low count [16:9]
    function automatic logic [DW-1:0] ctrl_word(input int en, input int hi, input int lo);
        return (DW'(lo) << 9) | (DW'(hi) << 1) | DW'(en & 1);
    endfunction

    task automatic reg_write(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [DW-1:0] m, output logic [DW-1:0] n);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        m = rdata_m; n = rdata_n;
    endtask

    task automatic at_high(output int v);
        @(posedge clk); #2; v = int'(out_m);
    endtask

    task automatic at_low(output int v);
        @(negedge clk); #2; v = int'(out_m);
    endtask

    // Recorders and scoreboard monitor, sampled mid-way through clk high.
    int    rises_m = 0, falls_m = 0, cur_h_m = 0, last_h_m = 0;
    int    falls_n = 0;
    logic  prev_m = 1'b0, prev_n = 1'b0;
    int    exp_q[$];
    string mon_tag = "";
    bit    mon_on = 1'b0, mon_run = 1'b0, mon_started = 1'b0;
    logic  mon_level = 1'b0;
    int    mon_len = 0;

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (out_m && !prev_m) begin rises_m++; cur_h_m = 0; end
            if (out_m) cur_h_m++;
            if (!out_m && prev_m) begin falls_m++; last_h_m = cur_h_m; end
            if (!out_n && prev_n) falls_n++;

            if (mon_on) begin
                if (!mon_run) begin
                    if (out_m && !prev_m) begin
                        mon_run = 1'b1; mon_started = 1'b1;
                        mon_level = 1'b1; mon_len = 1;
                    end
                end else if (out_m == mon_level) begin
                    mon_len++;
                end else begin
                    check(mon_len, exp_q.pop_front(), mon_tag);
                    mon_level = out_m; mon_len = 1;
                    if (exp_q.size() == 0) begin mon_on = 1'b0; mon_run = 1'b0; end
                end
            end
            prev_m = out_m;
            prev_n = out_n;
        end
    end

    task automatic run_pattern(input int hi, input int lo, input int periods, input string tag);
        reg_write(1'b0, ctrl_word(1, hi, lo));
        repeat (40) @(negedge clk);
        for (int i = 0; i < periods; i++) begin
            exp_q.push_back(hi + 1);
            exp_q.push_back(lo + 1);
        end
        mon_tag = tag;
        mon_on  = 1'b1;
        while (mon_on) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rm, rn;
        int v, f0, fn0, ones;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7 reset state
        reg_read(1'b0, rm, rn);
        check(int'(rm), 0, "R7 ctrl after reset");
        reg_read(1'b1, rm, rn);
        check(int'(rm), 1, "R7 gate after reset");
        check(int'(rn), 1, "R6 gate reads one without gate");
        at_high(v); check(v, 1, "R1 bypass parent high");
        at_low(v);  check(v, 0, "R1 bypass parent low");

        // R10 readback with junk in spare bits, R4 layout
        reg_write(1'b0, ctrl_word(1, 3, 1) | 32'hFFFE_0000);
        reg_read(1'b0, rm, rn);
        check(int'(rm), int'(ctrl_word(1, 3, 1)), "R10 ctrl readback R4");

        run_pattern(3, 1, 2, "R2 R3 hi3 lo1");
        run_pattern(0, 0, 2, "R3 minimum ratio 2");
        run_pattern(1, 4, 2, "R2 R3 hi1 lo4");
        run_pattern(7, 2, 1, "R2 R3 hi7 lo2");

        // R8: new counts land only after the running period
        reg_write(1'b0, ctrl_word(1, 5, 5));
        repeat (40) @(negedge clk);
        exp_q.push_back(6); exp_q.push_back(6);
        exp_q.push_back(2); exp_q.push_back(2);
        mon_tag = "R8 deferred update";
        mon_started = 1'b0;
        mon_on = 1'b1;
        while (!mon_started) @(negedge clk);
        repeat (2) @(negedge clk);
        reg_write(1'b0, ctrl_word(1, 1, 1));
        while (mon_on) @(negedge clk);

        // R9 / R5: close the gate mid high phase
        reg_write(1'b0, ctrl_word(1, 5, 5));
        repeat (40) @(negedge clk);
        f0 = rises_m;
        while (rises_m == f0) @(negedge clk);
        f0 = falls_m; fn0 = falls_n;
        reg_write(1'b1, 32'h0);
        repeat (40) @(negedge clk);
        check(falls_m - f0, 1, "R9 one fall after gate close");
        check(last_h_m, 6, "R9 high phase not cut");
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            at_high(v); ones += v;
        end
        check(ones, 0, "R5 gated output stays low");
        check(int'(falls_n - fn0 > 0), 1, "R6 ungated channel keeps running");
        reg_read(1'b1, rm, rn);
        check(int'(rm), 0, "R10 gate readback");
        check(int'(rn), 1, "R6 gate write ignored");

        // R9: reopen, first visible high is whole
        repeat (7) @(negedge clk);
        f0 = falls_m;
        reg_write(1'b1, 32'h1);
        while (falls_m == f0) @(negedge clk);
        check(last_h_m, 6, "R9 first high after reopen");

        // R1 return to bypass, R5 gate in bypass
        reg_write(1'b0, ctrl_word(0, 5, 5));
        repeat (30) @(negedge clk);
        at_high(v); check(v, 1, "R1 bypass again high");
        at_low(v);  check(v, 0, "R1 bypass again low");
        reg_write(1'b1, 32'h0);
        repeat (4) @(negedge clk);
        at_high(v); check(v, 0, "R5 bypass gated off");
        reg_write(1'b1, 32'h1);
        repeat (4) @(negedge clk);
        at_high(v); check(v, 1, "R5 bypass gated on");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule